// File: doc/BRIEF.md
# Pipelined Nine-Pixel Median Network

This block takes the nine pixels of a 3x3 neighbourhood in one clock and returns the median of the nine values. It also returns the smallest and the largest value of the same neighbourhood. The circuit is built only from three-input sorting cells, and those cells sit in four registered stages. A new neighbourhood can be presented on every clock. A valid strobe travels with the data through the pipeline.

The first stage orders each row. The second stage regroups the row results into the highs, the middles and the lows, and orders each group. At that point the neighbourhood maximum and minimum are already known, so they are brought out two cycles after the strobe. The third stage orders a triple made of the lowest high, the middle middle and the highest low. The fourth stage registers the middle of that triple, which is the median. Two extra registers delay the extrema so that all three results can also be read together on the median cycle.

Top module: `median9_net`

## Requirements
- R1: `med_o` equals the 5th smallest of the nine 8-bit unsigned pixels. Repeated values are handled correctly, including windows where all nine pixels are equal.
- R2: `max_o` equals the largest of the nine pixels and `min_o` equals the smallest.
- R3: `max_valid_o` and `min_valid_o` are high exactly 2 clock cycles after a cycle in which `valid_i` was high. They are low 2 cycles after a cycle in which `valid_i` was low.
- R4: `med_valid_o` is high exactly 4 clock cycles after a cycle in which `valid_i` was high. It is low 4 cycles after a cycle in which `valid_i` was low.
- R5: When `med_valid_o` is high, `max_late_o` and `min_late_o` carry the maximum and minimum of the same window that produced `med_o`.
- R6: Windows presented on consecutive cycles are processed independently, at a rate of one result per clock. Cycles with `valid_i` low between windows produce no result.
- R7: While `rst_ni` is low, every output and every valid flag is 0. This holds even when the reset arrives while the pipeline is full.
- R8: Whenever `med_valid_o` is high, `min_late_o` <= `med_o` <= `max_late_o`.
- R9: Pixel k of the window occupies `pix_i[8k+7:8k]`, with k from 0 to 8 in row-major order. The result does not depend on the order in which the pixels are placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Window strobe |
| pix_i | input | 72 | Nine pixels, pixel k at bits 8k+7:8k |
| max_o | output | 8 | Window maximum, available at stage 2 |
| min_o | output | 8 | Window minimum, available at stage 2 |
| max_valid_o | output | 1 | Valid flag for max_o |
| min_valid_o | output | 1 | Valid flag for min_o |
| med_o | output | 8 | Window median, available at stage 4 |
| med_valid_o | output | 1 | Valid flag for med_o and the late extrema |
| max_late_o | output | 8 | Maximum, delayed to line up with the median |
| min_late_o | output | 8 | Minimum, delayed to line up with the median |

## Verification
Several properties are checked by assertions on every clock cycle:
- each registered triple leaves its stage in descending order;
- the valid flags appear exactly two and four cycles after the strobe, and stay low after idle cycles;
- the late extrema equal the stage-2 extrema from two cycles earlier;
- the median lies between the late minimum and the late maximum.

Only the bench scenarios can show that the value returned is the true median, or the true minimum or maximum, of the window. To do this, the bench sweeps every window built from the levels 0, 128 and 255, which covers heavy repetition and the all-0, all-255 and all-equal cases. It then sweeps pseudo-random windows with idle gaps between them, and finally applies a reset while the pipeline is full.

// File: rtl/median9_pkg.sv
package median9_pkg;
  localparam int unsigned LANES = 3;
  localparam int unsigned WIN   = LANES * LANES;
  // slot order inside a sorted triple
  localparam int unsigned HI  = 0;
  localparam int unsigned MID = 1;
  localparam int unsigned LO  = 2;
endpackage

// File: rtl/median9_sort3.sv
module median9_sort3 #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] mid_o,
  output logic [W-1:0] lo_o
);
  logic         ab_ge, hc_ge, tl_ge;
  logic [W-1:0] h1, l1, rest;

  // non-strict compares keep ties stable
  always_comb begin
    ab_ge = a_i >= b_i;
    h1    = ab_ge ? a_i : b_i;
    l1    = ab_ge ? b_i : a_i;
    hc_ge = h1 >= c_i;
    hi_o  = hc_ge ? h1 : c_i;
    rest  = hc_ge ? c_i : h1;
    tl_ge = rest >= l1;
    mid_o = tl_ge ? rest : l1;
    lo_o  = tl_ge ? l1 : rest;
  end
endmodule

// File: rtl/median9_rank.sv
module median9_rank
  import median9_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned N = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic [N-1:0][2:0][W-1:0] trip_i,
  output logic                     vld_o,
  output logic [N-1:0][2:0][W-1:0] trip_o
);
  logic [N-1:0][2:0][W-1:0] sorted;

  for (genvar t = 0; t < N; t++) begin : g_cell
    median9_sort3 #(.W(W)) u_cell (
      .a_i  (trip_i[t][0]),
      .b_i  (trip_i[t][1]),
      .c_i  (trip_i[t][2]),
      .hi_o (sorted[t][HI]),
      .mid_o(sorted[t][MID]),
      .lo_o (sorted[t][LO])
    );

    // R1
    rank_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |-> (trip_o[t][HI] >= trip_o[t][MID]) && (trip_o[t][MID] >= trip_o[t][LO]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      trip_o <= '0;
    end else begin
      vld_o  <= vld_i;
      trip_o <= sorted;
    end
  end
endmodule

// File: rtl/median9_net.sv
module median9_net
  import median9_pkg::*;
#(
  parameter int unsigned W = 8,
  localparam int unsigned PW = WIN * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [PW-1:0] pix_i,
  output logic [W-1:0]  max_o,
  output logic [W-1:0]  min_o,
  output logic          max_valid_o,
  output logic          min_valid_o,
  output logic [W-1:0]  med_o,
  output logic          med_valid_o,
  output logic [W-1:0]  max_late_o,
  output logic [W-1:0]  min_late_o
);
  logic [2:0][2:0][W-1:0] s1_in, s1, s2_in, s2;
  logic [0:0][2:0][W-1:0] s3_in, s3;
  logic                   v1, v2, v3;
  logic [W-1:0]           max_d1, min_d1;

  // stage 1 takes rows, stage 2 takes the transposed rank groups
  for (genvar r = 0; r < LANES; r++) begin : g_row
    for (genvar k = 0; k < LANES; k++) begin : g_col
      assign s1_in[r][k] = pix_i[(r*LANES+k)*W +: W];
      assign s2_in[r][k] = s1[k][r];
    end
  end

  assign s3_in[0][0] = s2[HI][LO];
  assign s3_in[0][1] = s2[MID][MID];
  assign s3_in[0][2] = s2[LO][HI];

  median9_rank #(.W(W), .N(LANES)) u_rows (
    .clk_i, .rst_ni, .vld_i(valid_i), .trip_i(s1_in), .vld_o(v1), .trip_o(s1));
  median9_rank #(.W(W), .N(LANES)) u_groups (
    .clk_i, .rst_ni, .vld_i(v1), .trip_i(s2_in), .vld_o(v2), .trip_o(s2));
  median9_rank #(.W(W), .N(1)) u_diag (
    .clk_i, .rst_ni, .vld_i(v2), .trip_i(s3_in), .vld_o(v3), .trip_o(s3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      med_valid_o <= 1'b0;
      med_o       <= '0;
      max_d1      <= '0;
      min_d1      <= '0;
      max_late_o  <= '0;
      min_late_o  <= '0;
    end else begin
      med_valid_o <= v3;
      med_o       <= s3[0][MID];
      max_d1      <= s2[HI][HI];
      min_d1      <= s2[LO][LO];
      max_late_o  <= max_d1;
      min_late_o  <= min_d1;
    end
  end

  assign max_o       = s2[HI][HI];
  assign min_o       = s2[LO][LO];
  assign max_valid_o = v2;
  assign min_valid_o = v2;

  // R3
  ext_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 (max_valid_o && min_valid_o));
  // R3
  ext_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 (!max_valid_o && !min_valid_o));
  // R4
  med_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##4 med_valid_o);
  // R4
  med_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##4 !med_valid_o);
  // R5
  late_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_valid_o |-> ##2 (max_late_o == $past(max_o, 2) && min_late_o == $past(min_o, 2)));
  // R8
  late_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    med_valid_o |-> (min_late_o <= med_o && med_o <= max_late_o));
  // R8
  diag_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v3 |-> (s3[0][HI] <= max_d1 && s3[0][LO] >= min_d1));

  for (genvar g = 0; g < LANES; g++) begin : g_bnd
    for (genvar e = 0; e < LANES; e++) begin : g_el
      // R2
      ext_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v2 |-> (s2[g][e] <= max_o && s2[g][e] >= min_o));
    end
  end
endmodule

// File: tb/sim_median9_net.sv
`timescale 1ns/1ps
module sim_median9_net;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vin = 1'b0;
  logic [71:0] pix = '0;
  logic [7:0]  max_w, min_w, med_w, maxl_w, minl_w;
  logic        maxv_w, minv_w, medv_w;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;
  logic        hv [0:4];
  logic [71:0] hw [0:4];
  logic [31:0] lfsr = 32'hACE1_1234;

  always #2 clk = ~clk;

  median9_net u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .pix_i(pix),
    .max_o(max_w), .min_o(min_w), .max_valid_o(maxv_w), .min_valid_o(minv_w),
    .med_o(med_w), .med_valid_o(medv_w), .max_late_o(maxl_w), .min_late_o(minl_w));

  function automatic logic [7:0] rank_of(input logic [71:0] w, input int k);
    logic [7:0] a [0:8];
    logic [7:0] t;
    for (int i = 0; i < 9; i++) a[i] = w[8*i +: 8];
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 8 - i; j++)
        if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    return a[k];
  endfunction

  task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 5; i++) begin hv[i] = 1'b0; hw[i] = '0; end
  endtask

  // check the outputs of the current cycle, then apply the next window
  task automatic step(input logic v, input logic [71:0] w);
    @(negedge clk);
    cmp("R3 ext valid", {7'd0, maxv_w}, {7'd0, hv[1]});
    cmp("R3 ext valid", {7'd0, minv_w}, {7'd0, hv[1]});
    cmp("R4 med valid", {7'd0, medv_w}, {7'd0, hv[3]});
    if (hv[1]) begin
      cmp("R2 max", max_w, rank_of(hw[1], 8));
      cmp("R2 min", min_w, rank_of(hw[1], 0));
    end
    if (hv[3]) begin
      cmp("R1 median", med_w, rank_of(hw[3], 4));
      cmp("R5 late max", maxl_w, rank_of(hw[3], 8));
      cmp("R5 late min", minl_w, rank_of(hw[3], 0));
    end
    for (int i = 4; i > 0; i--) begin hv[i] = hv[i-1]; hw[i] = hw[i-1]; end
    hv[0] = v;
    hw[0] = w;
    vin   = v;
    pix   = w;
  endtask

  task automatic check_zero(input string req);
    cmp(req, {5'd0, maxv_w, minv_w, medv_w}, 8'd0);
    cmp(req, max_w | min_w | med_w | maxl_w | minl_w, 8'd0);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    clear_hist();
    // R7: reset holds outputs at zero even with a strobe present
    vin = 1'b1;
    pix = {9{8'hA5}};
    repeat (3) @(negedge clk);
    check_zero("R7 reset");
    vin = 1'b0;
    rst_n = 1'b1;

    // R1 corner windows: all 0, all 255, all equal
    step(1'b1, '0);
    step(1'b1, {9{8'hFF}});
    step(1'b1, {9{8'h37}});

    // R1 R2 R6: every window over levels {0,128,255}, idle gap every 7th
    for (int idx = 0; idx < 19683; idx++) begin
      logic [71:0] w;
      int q;
      q = idx;
      for (int p = 0; p < 9; p++) begin
        w[8*p +: 8] = (q % 3 == 0) ? 8'd0 : (q % 3 == 1) ? 8'd128 : 8'd255;
        q = q / 3;
      end
      step(1'b1, w);
      if (idx % 7 == 6) step(1'b0, ~w); // R3 R4: idle data yields nothing
    end

    // R9 R6: pseudo-random windows; a permuted copy must give the same result
    for (int n = 0; n < 2000; n++) begin
      logic [71:0] w;
      for (int p = 0; p < 9; p++) begin
        lfsr = nxt(lfsr);
        w[8*p +: 8] = lfsr[7:0] & ((n % 3 == 0) ? 8'h0F : 8'hFF);
      end
      step(1'b1, w);
      step(1'b1, {w[7:0], w[71:8]});
      if (n % 5 == 0) step(1'b0, w);
    end

    // R7: reset while the pipeline is full
    for (int n = 0; n < 4; n++) step(1'b1, {9{8'(n * 40 + 7)}});
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_zero("R7 midrun reset");
    clear_hist();
    vin = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 6; n++) step(1'b0, '0);
    step(1'b1, {8'd9, 8'd1, 8'd8, 8'd2, 8'd7, 8'd3, 8'd6, 8'd4, 8'd5});
    for (int n = 0; n < 5; n++) step(1'b0, '0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule